// File: doc/BRIEF.md
# Heartbeat-Gated Watchdog Kicker

This block keeps a short-period hardware watchdog from expiring for as long as a slow software heartbeat keeps arriving. It runs on two time bases. A fast kick timer, counted in millisecond ticks, fires a little inside the watchdog's overflow period. Each time it fires, the block clears the watchdog overflow flag and zeroes the watchdog counter. A separate heartbeat deadline, counted in one-second ticks, is reloaded by software keepalive pulses. When a kick falls due after that deadline has run out, the kick is withheld and the kick timer disarms. A heartbeat-lost flag is raised, and the watchdog is left to expire.

Software programs the heartbeat timeout in whole seconds. Each request is answered with an accept or reject pulse. Start and stop commands set and clear the watchdog's enable. A no-way-out input can lock the watchdog on once it has been started. The clock-select code and the initial timeout are sampled while reset is high, and each falls back to a default if its value is invalid. The watchdog itself lies outside this block.

Top module: `hb_wdog_kicker`

## Requirements
- R1: While reset is high and in the first cycle after it, `wd_en_o`, `wd_wt_mode_o`, `wd_cnt_clr_o`, `wd_ovf_clr_o`, `wd_rsts_clr_o` and `hb_lost_o` are 0, and `wd_cks_o` holds the clock select sampled in reset.
- R2: A `tmo_wr_i` with a value in 1..3600 stores that value as the timeout and gives a one-cycle `tmo_ok_o` pulse in the next cycle.
- R3: A `tmo_wr_i` with a value outside 1..3600 gives a one-cycle `tmo_err_o` pulse, and the stored timeout is left unchanged.
- R4: The stored timeout is taken from `init_tmo_i` during reset when that value is in 1..3600, and is 30 seconds otherwise.
- R5: An accepted start enables the watchdog (`wd_en_o`=1, `wd_wt_mode_o`=1) and pulses `wd_cnt_clr_o` and `wd_rsts_clr_o` for one cycle in the next cycle. It also clears `hb_lost_o`, loads the heartbeat deadline and arms the kick timer.
- R6: The kick interval, in `ms_tick_i` pulses, is the overflow period in ms of the selected clock code minus 4. With default parameters, codes 5, 6 and 7 give 2, 4 and 8. A code outside 5..7 sampled in reset selects code 7.
- R7: When the kick timer falls due while the deadline is unexpired, `wd_ovf_clr_o` and `wd_cnt_clr_o` pulse together for one cycle in the next cycle, and the next kick is scheduled one interval later.
- R8: A keepalive reloads the heartbeat deadline to the stored timeout in seconds and drives no watchdog output.
- R9: When a kick falls due after the deadline has reached zero, no clear pulse is issued, `hb_lost_o` rises and stays high, and no further kick occurs until the next start, keepalives included.
- R10: An accepted stop clears `wd_en_o` in the next cycle and disarms the kick timer.
- R11: When `no_way_out_i` is 1 and a start has been accepted since reset, stop is ignored: `wd_en_o` stays 1 and kicks continue.
- R12: Only one command acts per cycle. An accepted stop overrides a start or a due kick in the same cycle. A start overrides a due kick and restarts the kick interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_tmo_i | input | 12 | Initial timeout in seconds, sampled in reset |
| cfg_cks_i | input | 3 | Watchdog clock-select code, sampled in reset |
| no_way_out_i | input | 1 | Makes stop ineffective after a start |
| start_i | input | 1 | Start command pulse |
| stop_i | input | 1 | Stop command pulse |
| keepalive_i | input | 1 | Software heartbeat pulse |
| tmo_wr_i | input | 1 | Timeout write request |
| tmo_val_i | input | 12 | Requested timeout in seconds |
| tmo_ok_o | output | 1 | Timeout request accepted (pulse) |
| tmo_err_o | output | 1 | Timeout request rejected (pulse) |
| sec_tick_i | input | 1 | One-second time base pulse |
| ms_tick_i | input | 1 | Millisecond time base pulse |
| wd_en_o | output | 1 | Watchdog timer enable |
| wd_wt_mode_o | output | 1 | Watchdog set to interval-timer-with-reset mode |
| wd_cks_o | output | 3 | Watchdog clock-select code |
| wd_cnt_clr_o | output | 1 | Zero the watchdog counter (pulse) |
| wd_ovf_clr_o | output | 1 | Clear the watchdog overflow flag (pulse) |
| wd_rsts_clr_o | output | 1 | Clear the watchdog reset-select bit (pulse) |
| hb_lost_o | output | 1 | Heartbeat deadline missed, kicking halted |

## Verification
A wrong kick count shows up as a clear pulse one millisecond tick early or late, against an interval known exactly from the clock code. A wrong deadline count shows up as a kick that is withheld while the deadline is still live, or issued once it has lapsed. That difference is visible at the first kick due after the boundary second. Timeout storage has no readback, so a stored value is checked through the number of second ticks the deadline survives. The arbitration between commands is checked by pulsing start, stop and a due millisecond tick in the same cycle and reading the enable and clear outputs one cycle later.

// File: rtl/hbk_pkg.sv
package hbk_pkg;
  localparam int unsigned TMO_W       = 12;
  localparam int unsigned TMO_MIN_S   = 1;
  localparam int unsigned TMO_MAX_S   = 3600;
  localparam int unsigned TMO_DEF_S   = 30;
  localparam int unsigned KICK_W      = 8;
  localparam logic [2:0]  CKS_LO      = 3'd5;
  localparam logic [2:0]  CKS_MID     = 3'd6;
  localparam logic [2:0]  CKS_HI      = 3'd7;
  localparam logic [2:0]  CKS_DEF     = CKS_HI;
  localparam int unsigned KICK_MARGIN = 4;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_STOP  = 2'd1,
    CMD_START = 2'd2,
    CMD_KICK  = 2'd3
  } cmd_e;
endpackage

// File: rtl/hbk_tmo_reg.sv
module hbk_tmo_reg #(
  parameter int unsigned TW    = hbk_pkg::TMO_W,
  parameter int unsigned T_MIN = hbk_pkg::TMO_MIN_S,
  parameter int unsigned T_MAX = hbk_pkg::TMO_MAX_S,
  parameter int unsigned T_DEF = hbk_pkg::TMO_DEF_S
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] init_val,
  input  logic          wr,
  input  logic [TW-1:0] wr_val,
  output logic [TW-1:0] tmo_q,
  output logic          ok_q,
  output logic          err_q
);
  localparam logic [TW-1:0] LO  = TW'(T_MIN);
  localparam logic [TW-1:0] HI  = TW'(T_MAX);
  localparam logic [TW-1:0] DEF = TW'(T_DEF);

  logic init_in_range, wr_in_range;
  assign init_in_range = (init_val >= LO) && (init_val <= HI);
  assign wr_in_range   = (wr_val >= LO) && (wr_val <= HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q <= init_in_range ? init_val : DEF;
      ok_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ok_q  <= wr && wr_in_range;
      err_q <= wr && !wr_in_range;
      if (wr && wr_in_range) tmo_q <= wr_val;
    end
  end
endmodule

// File: rtl/hbk_deadline.sv
module hbk_deadline #(
  parameter int unsigned TW = hbk_pkg::TMO_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          sec_tick,
  output logic          alive
);
  logic [TW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)                            remain_q <= '0;
    else if (load)                      remain_q <= load_val;
    else if (sec_tick && remain_q != 0) remain_q <= remain_q - 1'b1;
  end

  assign alive = (remain_q != '0);
endmodule

// File: rtl/hbk_kick_timer.sv
module hbk_kick_timer #(
  parameter int unsigned KW = hbk_pkg::KICK_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          kill,
  input  logic [KW-1:0] interval,
  input  logic          ms_tick,
  output logic          due
);
  logic          armed_q;
  logic [KW-1:0] cnt_q;

  assign due = armed_q && ms_tick && (cnt_q == KW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (kill) begin
      armed_q <= 1'b0;
    end else if (load) begin
      armed_q <= 1'b1;
      cnt_q   <= interval;
    end else if (armed_q && ms_tick) begin
      cnt_q <= (cnt_q == KW'(1)) ? interval : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/hb_wdog_kicker.sv
module hb_wdog_kicker #(
  parameter int unsigned TMO_W    = hbk_pkg::TMO_W,
  parameter int unsigned TMO_MIN  = hbk_pkg::TMO_MIN_S,
  parameter int unsigned TMO_MAX  = hbk_pkg::TMO_MAX_S,
  parameter int unsigned TMO_DEF  = hbk_pkg::TMO_DEF_S,
  parameter int unsigned KICK_W   = hbk_pkg::KICK_W,
  parameter int unsigned OVF_MS_5 = 6,
  parameter int unsigned OVF_MS_6 = 8,
  parameter int unsigned OVF_MS_7 = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TMO_W-1:0] init_tmo_i,
  input  logic [2:0]       cfg_cks_i,
  input  logic             no_way_out_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             keepalive_i,
  input  logic             tmo_wr_i,
  input  logic [TMO_W-1:0] tmo_val_i,
  output logic             tmo_ok_o,
  output logic             tmo_err_o,
  input  logic             sec_tick_i,
  input  logic             ms_tick_i,
  output logic             wd_en_o,
  output logic             wd_wt_mode_o,
  output logic [2:0]       wd_cks_o,
  output logic             wd_cnt_clr_o,
  output logic             wd_ovf_clr_o,
  output logic             wd_rsts_clr_o,
  output logic             hb_lost_o
);
  import hbk_pkg::*;

  localparam logic [KICK_W-1:0] KI_5 = KICK_W'(OVF_MS_5 - KICK_MARGIN);
  localparam logic [KICK_W-1:0] KI_6 = KICK_W'(OVF_MS_6 - KICK_MARGIN);
  localparam logic [KICK_W-1:0] KI_7 = KICK_W'(OVF_MS_7 - KICK_MARGIN);

  logic [TMO_W-1:0]  tmo_q;
  logic [KICK_W-1:0] interval;
  logic              started_q;
  logic              hb_alive, kick_due;
  logic              stop_ok;
  cmd_e              cmd;

  hbk_tmo_reg #(.TW(TMO_W), .T_MIN(TMO_MIN), .T_MAX(TMO_MAX), .T_DEF(TMO_DEF)) u_tmo (
    .clk(clk), .rst(rst), .init_val(init_tmo_i), .wr(tmo_wr_i), .wr_val(tmo_val_i),
    .tmo_q(tmo_q), .ok_q(tmo_ok_o), .err_q(tmo_err_o)
  );

  // Arbitration: one watchdog update per cycle, stop > start > kick
  assign stop_ok = stop_i && !(no_way_out_i && started_q);

  always_comb begin
    if (stop_ok)       cmd = CMD_STOP;
    else if (start_i)  cmd = CMD_START;
    else if (kick_due) cmd = CMD_KICK;
    else               cmd = CMD_NONE;
  end

  hbk_deadline #(.TW(TMO_W)) u_deadline (
    .clk(clk), .rst(rst),
    .load(cmd == CMD_START || keepalive_i),
    .load_val(tmo_q), .sec_tick(sec_tick_i), .alive(hb_alive)
  );

  always_comb begin
    case (wd_cks_o)
      CKS_LO:  interval = KI_5;
      CKS_MID: interval = KI_6;
      default: interval = KI_7;
    endcase
  end

  hbk_kick_timer #(.KW(KICK_W)) u_kick (
    .clk(clk), .rst(rst),
    .load(cmd == CMD_START),
    .kill(cmd == CMD_STOP || (cmd == CMD_KICK && !hb_alive)),
    .interval(interval), .ms_tick(ms_tick_i), .due(kick_due)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_cks_o      <= (cfg_cks_i >= CKS_LO && cfg_cks_i <= CKS_HI) ? cfg_cks_i : CKS_DEF;
      wd_en_o       <= 1'b0;
      wd_wt_mode_o  <= 1'b0;
      wd_cnt_clr_o  <= 1'b0;
      wd_ovf_clr_o  <= 1'b0;
      wd_rsts_clr_o <= 1'b0;
      hb_lost_o     <= 1'b0;
      started_q     <= 1'b0;
    end else begin
      wd_cnt_clr_o  <= 1'b0;
      wd_ovf_clr_o  <= 1'b0;
      wd_rsts_clr_o <= 1'b0;
      case (cmd)
        CMD_STOP: wd_en_o <= 1'b0;
        CMD_START: begin
          wd_en_o       <= 1'b1;
          wd_wt_mode_o  <= 1'b1;
          wd_cnt_clr_o  <= 1'b1;
          wd_rsts_clr_o <= 1'b1;
          hb_lost_o     <= 1'b0;
          started_q     <= 1'b1;
        end
        CMD_KICK: begin
          if (hb_alive) begin
            wd_ovf_clr_o <= 1'b1;
            wd_cnt_clr_o <= 1'b1;
          end else begin
            hb_lost_o <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hbk_chk.sv
module hbk_chk (
  input logic clk,
  input logic rst,
  input logic no_way_out_i,
  input logic start_i,
  input logic tmo_ok_o,
  input logic tmo_err_o,
  input logic wd_en_o,
  input logic wd_cnt_clr_o,
  input logic wd_ovf_clr_o,
  input logic wd_rsts_clr_o,
  input logic hb_lost_o
);
  // R2
  tmo_resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(tmo_ok_o && tmo_err_o));

  // R7
  kick_pair_chk: assert property (@(posedge clk) disable iff (rst)
    wd_ovf_clr_o |-> wd_cnt_clr_o);

  // R5
  start_seq_chk: assert property (@(posedge clk) disable iff (rst)
    wd_rsts_clr_o |-> (wd_en_o && wd_cnt_clr_o && !hb_lost_o));

  // R9
  lost_no_kick_chk: assert property (@(posedge clk) disable iff (rst)
    (hb_lost_o && !start_i) |=> !wd_ovf_clr_o);

  // R10
  kick_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    wd_ovf_clr_o |-> wd_en_o);

  // R11
  no_way_out_chk: assert property (@(posedge clk) disable iff (rst)
    (wd_en_o && no_way_out_i) |=> wd_en_o);
endmodule

bind hb_wdog_kicker hbk_chk u_hbk_chk (
  .clk(clk), .rst(rst), .no_way_out_i(no_way_out_i), .start_i(start_i),
  .tmo_ok_o(tmo_ok_o), .tmo_err_o(tmo_err_o), .wd_en_o(wd_en_o),
  .wd_cnt_clr_o(wd_cnt_clr_o), .wd_ovf_clr_o(wd_ovf_clr_o),
  .wd_rsts_clr_o(wd_rsts_clr_o), .hb_lost_o(hb_lost_o)
);

// File: tb/hb_wdog_kicker_tb.sv
module hb_wdog_kicker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] init_tmo = 12'd2;
  logic [2:0]  cfg_cks = 3'd5;
  logic        nwo = 1'b0, start = 1'b0, stop = 1'b0, kal = 1'b0;
  logic        twr = 1'b0, sec = 1'b0, ms = 1'b0;
  logic [11:0] tval = '0;
  logic        tok, terr, en, wt, cclr, oclr, rclr, lost;
  logic [2:0]  cks;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  hb_wdog_kicker u_dut (
    .clk(clk), .rst(rst), .init_tmo_i(init_tmo), .cfg_cks_i(cfg_cks),
    .no_way_out_i(nwo), .start_i(start), .stop_i(stop), .keepalive_i(kal),
    .tmo_wr_i(twr), .tmo_val_i(tval), .tmo_ok_o(tok), .tmo_err_o(terr),
    .sec_tick_i(sec), .ms_tick_i(ms), .wd_en_o(en), .wd_wt_mode_o(wt),
    .wd_cks_o(cks), .wd_cnt_clr_o(cclr), .wd_ovf_clr_o(oclr),
    .wd_rsts_clr_o(rclr), .hb_lost_o(lost)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [11:0] it, input logic [2:0] ck);
    @(negedge clk);
    rst = 1'b1; init_tmo = it; cfg_cks = ck;
    start = 0; stop = 0; kal = 0; twr = 0; sec = 0; ms = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // One-cycle pulses; outputs from the capturing edge are sampled on return
  task automatic p_start();  start = 1; @(negedge clk); start = 0; endtask
  task automatic p_stop();   stop  = 1; @(negedge clk); stop  = 0; endtask
  task automatic p_kal();    kal   = 1; @(negedge clk); kal   = 0; endtask
  task automatic p_ms();     ms    = 1; @(negedge clk); ms    = 0; endtask
  task automatic p_sec(input int n);
    for (int i = 0; i < n; i++) begin sec = 1; @(negedge clk); sec = 0; @(negedge clk); end
  endtask
  task automatic p_tmo(input logic [11:0] v);
    tval = v; twr = 1; @(negedge clk); twr = 0;
  endtask
  // n ms ticks; expect a kick only on the last when kick_last
  task automatic ms_run(input int n, input bit kick_last, input string req);
    for (int i = 1; i <= n; i++) begin
      p_ms();
      chk(req, oclr, (i == n) ? int'(kick_last) : 0);
      @(negedge clk);
      chk(req, oclr, 0);
    end
  endtask

  task automatic t_reset();
    chk("R1 en", en, 0);      chk("R1 wt", wt, 0);
    chk("R1 cclr", cclr, 0);  chk("R1 oclr", oclr, 0);
    chk("R1 rclr", rclr, 0);  chk("R1 lost", lost, 0);
    chk("R1 cks", cks, 5);
  endtask

  task automatic t_start();
    p_start();
    chk("R5 en", en, 1); chk("R5 wt", wt, 1);
    chk("R5 cclr", cclr, 1); chk("R5 rclr", rclr, 1); chk("R5 oclr", oclr, 0);
    @(negedge clk);
    chk("R5 pulse end", cclr, 0);
  endtask

  task automatic t_kick();
    ms_run(2, 1, "R6 R7 first kick code5");
    chk("R7 cclr with kick", cclr, 0);
    ms_run(2, 1, "R7 periodic kick");
  endtask

  task automatic t_deadline();
    p_sec(1);
    p_kal();
    chk("R8 keepalive no cclr", cclr, 0);
    chk("R8 keepalive no oclr", oclr, 0);
    p_sec(1);
    ms_run(2, 1, "R8 reloaded deadline alive");
    p_sec(1);
    ms_run(2, 0, "R9 expired no kick");
    chk("R9 lost", lost, 1);
    p_kal();
    ms_run(4, 0, "R9 no kick after keepalive");
    chk("R9 lost sticky", lost, 1);
    p_start();
    chk("R5 restart clears lost", lost, 0);
    ms_run(2, 1, "R5 restart rearms");
  endtask

  task automatic t_stop();
    p_stop();
    chk("R10 en cleared", en, 0);
    ms_run(4, 0, "R10 no kick after stop");
  endtask

  task automatic t_tmo();
    p_tmo(12'd3601); chk("R3 err 3601", terr, 1); chk("R3 ok 3601", tok, 0);
    p_tmo(12'd0);    chk("R3 err 0", terr, 1);
    p_tmo(12'd3600); chk("R2 ok 3600", tok, 1); chk("R2 err 3600", terr, 0);
    p_tmo(12'd3);    chk("R2 ok 3", tok, 1);
    @(negedge clk);  chk("R2 pulse end", tok, 0);
    p_tmo(12'd0);    chk("R3 err 0 again", terr, 1);
    p_start();
    p_sec(2);
    ms_run(2, 1, "R3 timeout 3 kept alive");
    p_sec(1);
    ms_run(2, 0, "R2 timeout 3 expired");
  endtask

  task automatic t_fallback();
    do_reset(12'd0, 3'd3);
    chk("R6 invalid cks to 7", cks, 7);
    p_start();
    p_sec(29);
    ms_run(8, 1, "R4 R6 default 30s interval 8");
    p_sec(1);
    ms_run(8, 0, "R4 30s expired");
    chk("R4 lost", lost, 1);
  endtask

  task automatic t_nowayout();
    do_reset(12'd5, 3'd6);
    nwo = 1;
    p_start();
    p_stop();
    chk("R11 stop ignored", en, 1);
    ms_run(4, 1, "R11 R6 kick continues code6");
    nwo = 0;
  endtask

  task automatic t_prio();
    do_reset(12'd5, 3'd5);
    p_start();
    start = 1; stop = 1; @(negedge clk); start = 0; stop = 0;
    chk("R12 stop over start en", en, 0);
    chk("R12 stop over start cclr", cclr, 0);
    p_start();
    p_ms();
    start = 1; ms = 1; @(negedge clk); start = 0; ms = 0;
    chk("R12 start over kick rclr", rclr, 1);
    chk("R12 start over kick oclr", oclr, 0);
    ms_run(2, 1, "R12 interval restarted");
    p_ms();
    stop = 1; ms = 1; @(negedge clk); stop = 0; ms = 0;
    chk("R12 stop over kick en", en, 0);
    chk("R12 stop over kick oclr", oclr, 0);
  endtask

  initial begin
    do_reset(12'd2, 3'd5);
    t_reset();
    t_start();
    t_kick();
    t_deadline();
    t_stop();
    t_tmo();
    t_fallback();
    t_nowayout();
    t_prio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule